// File: doc/BRIEF.md
# Interrupt Acknowledge Byte Sequencer

This block sits between an interrupt controller's priority logic and the CPU data bus. It answers a three-pulse interrupt acknowledge sequence. On the first active-low acknowledge pulse it drives a call opcode onto the bus. It also strobes the priority logic so that the winning level is moved into the in-service register and its request bit is cleared. On the second and third pulses it drives the low byte and then the high byte of the service routine address.

The service address is the programmed vector base plus the winning level times four. Both the level and the base are captured on the first pulse, so the address stays fixed for the rest of the sequence. When automatic end-of-interrupt is enabled and the controller is a master, the block issues a one-cycle strobe after the trailing edge of the third pulse. On a slave the automatic end-of-interrupt flag has no effect. Without that strobe, the in-service bit stays set until software clears it.

The acknowledge strobe is sampled synchronously. Its edges are detected with a one-cycle history register.

Top module: `intack_seq`

## Requirements
- R1: After reset, `isr_set` and `aeoi_pulse` are low, and the first acknowledge pulse that follows is treated as pulse one of a sequence.
- R2: `data_oe` is high exactly while `ack_n` is low. While `data_oe` is low, `data_out` is 8'h00.
- R3: During the first acknowledge pulse of a sequence, `data_out` is the call opcode 8'hCD.
- R4: `isr_set` is high for exactly one clock, in the cycle after the falling edge of `ack_n` that opens pulse one. The second and third pulses do not raise it.
- R5: During the second pulse, `data_out` is bits [7:0] of (`vec_base` + 4 × `win_lvl`).
- R6: During the third pulse, `data_out` is bits [15:8] of that same sum, including any carry out of the low byte.
- R7: When `auto_eoi_en` and `is_master` are both 1, `aeoi_pulse` is high for exactly one clock, in the cycle after the rising edge of `ack_n` that ends the third pulse.
- R8: When `is_master` is 0, `aeoi_pulse` stays low through the whole sequence, whatever the value of `auto_eoi_en`.
- R9: When `auto_eoi_en` is 0, `aeoi_pulse` stays low on a master.
- R10: After the third pulse the sequencer returns to idle, so the next pulse again yields the opcode and a new `isr_set`.
- R11: `win_lvl` and `vec_base` are captured at the first pulse. Changes to them during pulses two and three do not alter the address bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_n | input | 1 | Active-low interrupt acknowledge strobe from the CPU |
| win_lvl | input | 3 | Level chosen by the priority logic |
| vec_base | input | 16 | Programmed service routine base address |
| auto_eoi_en | input | 1 | Automatic end-of-interrupt enable |
| is_master | input | 1 | 1 when this controller is the master |
| data_out | output | 8 | Byte driven onto the data bus |
| data_oe | output | 1 | Data bus output enable |
| isr_set | output | 1 | Strobe to latch the winning level into in-service |
| aeoi_pulse | output | 1 | Automatic end-of-interrupt strobe |

## Verification
The embedded assertions check the following on every cycle:
- the bus is quiet whenever the output is disabled;
- both strobes last a single cycle and never coincide;
- `isr_set` follows a low-sampled strobe;
- `aeoi_pulse` appears only when the previous cycle had both the master role and the flag set;
- the pulse counter never leaves its three legal values.

Some behaviour can only be shown by the directed scenarios. These scenarios cover:
- the byte order across a full sequence;
- the address arithmetic, including the carry into the high byte;
- capture of the level and base at pulse one;
- suppression of the strobe on a slave and with the flag clear;
- the return to idle between sequences.

// File: rtl/intack_seq.sv
module intack_seq #(
  parameter int DW      = 8,
  parameter int LW      = 3,
  parameter int SPACING = 4,
  parameter logic [7:0] CALL_OP = 8'hCD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ack_n,
  input  logic [LW-1:0] win_lvl,
  input  logic [2*DW-1:0] vec_base,
  input  logic          auto_eoi_en,
  input  logic          is_master,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic          isr_set,
  output logic          aeoi_pulse
);
  localparam int AW = 2 * DW;

  logic          ack_q;
  logic [1:0]    phase;
  logic [AW-1:0] addr_q;
  logic          fall, rise;

  assign fall = ack_q & ~ack_n;
  assign rise = ~ack_q & ack_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q      <= 1'b1;
      phase      <= 2'd0;
      addr_q     <= '0;
      isr_set    <= 1'b0;
      aeoi_pulse <= 1'b0;
    end else begin
      ack_q      <= ack_n;
      isr_set    <= fall && (phase == 2'd0);
      aeoi_pulse <= rise && (phase == 2'd2) && auto_eoi_en && is_master;
      if (fall && phase == 2'd0)
        addr_q <= vec_base + AW'(win_lvl) * AW'(SPACING);
      if (rise)
        phase <= (phase == 2'd2) ? 2'd0 : phase + 2'd1;
    end
  end

  assign data_oe = ~ack_n;

  always_comb begin
    data_out = '0;
    if (data_oe) begin
      case (phase)
        2'd0:    data_out = CALL_OP;
        2'd1:    data_out = addr_q[DW-1:0];
        default: data_out = addr_q[AW-1:DW];
      endcase
    end
  end

  p_quiet_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> (data_out == '0));
  p_isr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    isr_set |=> !isr_set);
  p_isr_after_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    isr_set |-> !$past(ack_n));
  p_aeoi_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    aeoi_pulse |=> !aeoi_pulse);
  p_aeoi_master_r8: assert property (@(posedge clk) disable iff (!rst_n)
    aeoi_pulse |-> $past(is_master && auto_eoi_en));
  p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(isr_set && aeoi_pulse));
  p_phase_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3);
endmodule

// File: tb/intack_seq_bench.sv
module intack_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ack_n = 1'b1;
  logic [2:0]  win_lvl = '0;
  logic [15:0] vec_base = '0;
  logic        auto_eoi_en = 1'b0;
  logic        is_master = 1'b1;
  logic [7:0]  data_out;
  logic        data_oe, isr_set, aeoi_pulse;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  intack_seq u_intack_seq (
    .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .win_lvl(win_lvl),
    .vec_base(vec_base), .auto_eoi_en(auto_eoi_en), .is_master(is_master),
    .data_out(data_out), .data_oe(data_oe), .isr_set(isr_set),
    .aeoi_pulse(aeoi_pulse));

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One acknowledge pulse; captured values returned
  task automatic pulse(output logic [7:0] d, output logic oe, output logic isr1,
                       output logic isr2, output logic oe_off, output logic [7:0] d_off,
                       output logic ae1, output logic ae2);
    @(negedge clk) ack_n = 1'b0;
    @(negedge clk) begin d = data_out; oe = data_oe; isr1 = isr_set; end
    @(negedge clk) begin isr2 = isr_set; ack_n = 1'b1; end
    @(negedge clk) begin ae1 = aeoi_pulse; oe_off = data_oe; d_off = data_out; end
    @(negedge clk) ae2 = aeoi_pulse;
  endtask

  task automatic sequence3(input logic [15:0] exp_addr, input logic exp_ae,
                           input logic change_mid, input string name);
    logic [7:0] d; logic oe, i1, i2, oo, a1, a2; logic [7:0] doff;
    pulse(d, oe, i1, i2, oo, doff, a1, a2);
    check({name, " R3 opcode"}, 16'(d), 16'hCD);
    check({name, " R2 oe low strobe"}, 16'(oe), 16'd1);
    check({name, " R4 isr_set pulse"}, 16'(i1), 16'd1);
    check({name, " R4 isr_set one cycle"}, 16'(i2), 16'd0);
    check({name, " R2 oe off"}, 16'(oo), 16'd0);
    check({name, " R2 bus quiet"}, 16'(doff), 16'd0);
    check({name, " R7 no aeoi after pulse1"}, 16'(a1), 16'd0);
    if (change_mid) begin vec_base = 16'hFFFF; win_lvl = 3'd7; end
    pulse(d, oe, i1, i2, oo, doff, a1, a2);
    check({name, " R5/R11 low byte"}, 16'(d), 16'(exp_addr[7:0]));
    check({name, " R4 no isr_set on pulse2"}, 16'(i1), 16'd0);
    check({name, " R7 no aeoi after pulse2"}, 16'(a1), 16'd0);
    pulse(d, oe, i1, i2, oo, doff, a1, a2);
    check({name, " R6/R11 high byte"}, 16'(d), 16'(exp_addr[15:8]));
    check({name, " R4 no isr_set on pulse3"}, 16'(i1), 16'd0);
    check({name, " R7/R8/R9 aeoi"}, 16'(a1), 16'(exp_ae));
    check({name, " R7 aeoi one cycle"}, 16'(a2), 16'd0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R1 isr_set at reset", 16'(isr_set), 16'd0);
    check("R1 aeoi at reset", 16'(aeoi_pulse), 16'd0);
    check("R2 oe idle", 16'(data_oe), 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_master_aeoi;
    vec_base = 16'h2000; win_lvl = 3'd5; auto_eoi_en = 1'b1; is_master = 1'b1;
    sequence3(16'h2014, 1'b1, 1'b0, "master_aeoi");
  endtask

  task automatic t_slave;
    vec_base = 16'h4080; win_lvl = 3'd2; auto_eoi_en = 1'b1; is_master = 1'b0;
    sequence3(16'h4088, 1'b0, 1'b0, "slave R8");
  endtask

  task automatic t_no_flag;
    vec_base = 16'h0100; win_lvl = 3'd0; auto_eoi_en = 1'b0; is_master = 1'b1;
    sequence3(16'h0100, 1'b0, 1'b0, "noflag R9");
  endtask

  task automatic t_carry_capture;
    vec_base = 16'h12FC; win_lvl = 3'd3; auto_eoi_en = 1'b1; is_master = 1'b1;
    sequence3(16'h1308, 1'b1, 1'b1, "carry R11");
  endtask

  task automatic t_back_to_back;
    vec_base = 16'hA000; win_lvl = 3'd7; auto_eoi_en = 1'b0; is_master = 1'b1;
    sequence3(16'hA01C, 1'b0, 1'b0, "R10 seq a");
    vec_base = 16'hB004; win_lvl = 3'd1;
    sequence3(16'hB008, 1'b0, 1'b0, "R10 seq b");
  endtask

  initial begin
    t_reset();
    t_master_aeoi();
    t_slave();
    t_no_flag();
    t_carry_capture();
    t_back_to_back();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        vectors++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule